// File: doc/BRIEF.md
# FIFO Put-Transition Coverage Sequencer

This block is a built-in functional test controller for a queue channel that supports blocking requests. It drives the queue's operation port through a fixed list of steps, chosen so that every state change a put can cause is taken at least once. The list includes requests that are meant to block on a full or empty queue and the later requests that release them. It does not simply fill the queue and then empty it. After each step the controller compares the state the queue reports with the state it expects. It also compares any returned data word with a reference copy of the order in which data was written.

Write data comes from a 16-bit LFSR. A small reference queue inside the block holds every word put, in order, so that each returned word can be checked. The first mismatch latches a fail flag together with the index of the failing step. A queue that stops responding is caught by a response timeout. When the last step has been answered, or on a timeout, `done` rises and `pass` reports the verdict. The queue depth N (`DEPTH`, at least 3) is a parameter. The sequence has 2N+7 steps, numbered from 0.

Top module: `fts_put_cover_seq`

## Requirements
- R1: While `rst` is high, `op_valid`, `done`, `pass` and `fail` are 0. The first request is issued two clock edges after `rst` falls.
- R2: A request is a one-cycle pulse on `op_valid`. Its operation code is on `op_kind`: put=0, get=1, peek=2. No further request is issued until `rsp_valid` answers the current one.
- R3: Put data follows the LFSR x^16+x^14+x^13+x^11+1: next = {cur[14:0], cur[15]^cur[13]^cur[12]^cur[10]}. The first put carries the seed 16'hACE1, and the LFSR advances only on puts.
- R4: Steps 0..N are puts. The expected state codes are: semi-full=1 for steps 0..N-2, full=2 for step N-1, and put-blocked=3 for step N.
- R5: Steps N+1..2N+1 are gets, each returning the oldest word written. Step N+1 expects full=2 (it releases the blocked put), steps N+2..2N expect semi-full=1, and step 2N+1 expects empty=0.
- R6: Step 2N+2 is a get on the empty queue that expects get-blocked=4 and no data. Step 2N+3 is a put that expects empty=0 and returns its own word to the released get.
- R7: Step 2N+4 is a peek that expects peek-blocked=5 and no data. Step 2N+5 is a put that expects semi-full=1 and returns its own word. Step 2N+6 is a get that expects empty=0 and returns that same word.
- R8: A response fails the step if any of these holds: `rsp_state` differs from the expected code; `rsp_rdata_valid` differs from whether the step returns data; or the returned word differs from the reference copy.
- R9: `fail` latches on the first failing step. `fail_step` holds that step's index, and later mismatches change neither output.
- R10: If no response arrives within `TIMEOUT` cycles of waiting, the current step fails, `done` rises and no further request is issued.
- R11: After the response to step 2N+6, `done` rises and stays high, no further request is issued, and `pass` equals `done` and not `fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | output | 1 | One-cycle request strobe |
| op_kind | output | 2 | Operation code: put=0, get=1, peek=2 |
| op_wdata | output | 16 | Word carried by a put |
| rsp_valid | input | 1 | Response strobe for the outstanding request |
| rsp_state | input | 3 | Queue state after the request: 0 empty, 1 semi-full, 2 full, 3 put-blocked, 4 get-blocked, 5 peek-blocked |
| rsp_rdata_valid | input | 1 | A data word is returned with this response |
| rsp_rdata | input | 16 | Returned data word |
| done | output | 1 | Sequence finished |
| pass | output | 1 | Finished with no failure |
| fail | output | 1 | A step failed (sticky) |
| fail_step | output | clog2(2*DEPTH+7) | Index of the first failing step |

## Verification
The bench builds the block with DEPTH=5 and TIMEOUT=12. With depth 5 the semi-full run in both the fill and the drain phase lasts several steps, so off-by-one errors in the phase boundaries show up as wrong operation codes or state codes. With a short timeout the silent-queue case ends within a few dozen cycles. The queue model answers with a latency of one to three cycles depending on the step, so the wait-for-response logic is exercised. Injected faults on chosen steps drive the data, state and first-failure paths.

// File: rtl/fts_pkg.sv
package fts_pkg;

    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        OP_PUT  = 2'd0,
        OP_GET  = 2'd1,
        OP_PEEK = 2'd2
    } op_e;

    typedef enum logic [2:0] {
        ST_EMPTY    = 3'd0,
        ST_SEMI     = 3'd1,
        ST_FULL     = 3'd2,
        ST_BLK_PUT  = 3'd3,
        ST_BLK_GET  = 3'd4,
        ST_BLK_PEEK = 3'd5
    } qstate_e;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_POP  = 2'd1,
        RD_PEEK = 2'd2
    } rdchk_e;

    typedef struct packed {
        op_e     op;
        qstate_e exp_st;
        rdchk_e  rd;
    } step_t;

    function automatic int unsigned num_steps(int unsigned depth);
        return 2 * depth + 7;
    endfunction

    function automatic step_t mk_step(op_e o, qstate_e s, rdchk_e r);
        step_t t;
        t.op     = o;
        t.exp_st = s;
        t.rd     = r;
        return t;
    endfunction

    // Step table: fill, overfill, drain, blocked get, blocked peek.
    function automatic step_t step_of(int unsigned s, int unsigned n);
        step_t t;
        if (s < n - 1)           t = mk_step(OP_PUT,  ST_SEMI,     RD_NONE);
        else if (s == n - 1)     t = mk_step(OP_PUT,  ST_FULL,     RD_NONE);
        else if (s == n)         t = mk_step(OP_PUT,  ST_BLK_PUT,  RD_NONE);
        else if (s == n + 1)     t = mk_step(OP_GET,  ST_FULL,     RD_POP);
        else if (s <= 2 * n)     t = mk_step(OP_GET,  ST_SEMI,     RD_POP);
        else if (s == 2 * n + 1) t = mk_step(OP_GET,  ST_EMPTY,    RD_POP);
        else if (s == 2 * n + 2) t = mk_step(OP_GET,  ST_BLK_GET,  RD_NONE);
        else if (s == 2 * n + 3) t = mk_step(OP_PUT,  ST_EMPTY,    RD_POP);
        else if (s == 2 * n + 4) t = mk_step(OP_PEEK, ST_BLK_PEEK, RD_NONE);
        else if (s == 2 * n + 5) t = mk_step(OP_PUT,  ST_SEMI,     RD_PEEK);
        else                     t = mk_step(OP_GET,  ST_EMPTY,    RD_POP);
        return t;
    endfunction

    function automatic logic [DATA_W-1:0] lfsr_next(logic [DATA_W-1:0] v);
        return {v[DATA_W-2:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

endpackage

// File: rtl/fts_lfsr.sv
module fts_lfsr #(
    parameter logic [fts_pkg::DATA_W-1:0] SEED = 16'hACE1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      adv,
    output logic [fts_pkg::DATA_W-1:0] value
);
    logic [fts_pkg::DATA_W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst)      q <= SEED;
        else if (adv) q <= fts_pkg::lfsr_next(q);
    end

    assign value = q;

    // R3: a nonzero seed never reaches the all-zero lock-up word
    a_r3_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
        q != '0);

    // R3: each put moves the generator to a fresh word
    a_r3_lfsr_moves: assert property (@(posedge clk) disable iff (rst)
        adv |=> q != $past(q));

    // R3: the generator holds when no put is issued
    a_r3_lfsr_holds: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(q));
endmodule

// File: rtl/fts_ref_queue.sv
module fts_ref_queue #(
    parameter int ENTRIES = 5,
    parameter int W       = 16,
    localparam int PW     = $clog2(ENTRIES),
    localparam int CW     = $clog2(ENTRIES + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head
);
    logic [W-1:0]  mem [ENTRIES];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(ENTRIES - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign head = mem[rd_ptr];

    // R8: the reference copy never holds more words than the sequence writes
    a_r8_ref_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> cnt != CW'(ENTRIES));

    // R8: every checked return has a reference word behind it
    a_r8_ref_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop |-> cnt != '0);
endmodule

// File: rtl/fts_step_decode.sv
module fts_step_decode #(
    parameter int DEPTH  = 4,
    parameter int STEP_W = 4
) (
    input  logic [STEP_W-1:0] step_idx,
    output fts_pkg::step_t    cur,
    output logic              last
);
    localparam int NSTEPS = 2 * DEPTH + 7;

    always_comb begin
        cur  = fts_pkg::step_of(32'(step_idx), DEPTH);
        last = (step_idx == STEP_W'(NSTEPS - 1));
    end
endmodule

// File: rtl/fts_put_cover_seq.sv
module fts_put_cover_seq #(
    parameter int                         DEPTH   = 4,
    parameter int                         TIMEOUT = 64,
    parameter logic [fts_pkg::DATA_W-1:0] SEED    = 16'hACE1,
    localparam int                        STEP_W  = $clog2(2 * DEPTH + 7)
) (
    input  logic                       clk,
    input  logic                       rst,
    output logic                       op_valid,
    output logic [1:0]                 op_kind,
    output logic [fts_pkg::DATA_W-1:0] op_wdata,
    input  logic                       rsp_valid,
    input  logic [2:0]                 rsp_state,
    input  logic                       rsp_rdata_valid,
    input  logic [fts_pkg::DATA_W-1:0] rsp_rdata,
    output logic                       done,
    output logic                       pass,
    output logic                       fail,
    output logic [STEP_W-1:0]          fail_step
);
    import fts_pkg::*;

    localparam int TMO_W   = $clog2(TIMEOUT + 1);
    localparam int REF_ENT = DEPTH + 1;

    typedef enum logic [1:0] {
        SQ_START = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2,
        SQ_DONE  = 2'd3
    } seq_e;

    seq_e              state;
    logic [STEP_W-1:0] step;
    logic [TMO_W-1:0]  tmo;
    logic              fail_q;
    logic [STEP_W-1:0] fail_step_q;
    logic              done_q;

    step_t             cur;
    logic              last;
    logic [DATA_W-1:0] lfsr_q;
    logic [DATA_W-1:0] ref_head;
    logic              put_now;
    logic              take_rsp;
    logic              ref_pop;
    logic              want_data;
    logic              mismatch;

    fts_step_decode #(.DEPTH(DEPTH), .STEP_W(STEP_W)) u_dec (
        .step_idx (step),
        .cur      (cur),
        .last     (last)
    );

    fts_lfsr #(.SEED(SEED)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .adv   (put_now),
        .value (lfsr_q)
    );

    fts_ref_queue #(.ENTRIES(REF_ENT), .W(DATA_W)) u_ref (
        .clk       (clk),
        .rst       (rst),
        .push      (put_now),
        .push_data (lfsr_q),
        .pop       (ref_pop),
        .head      (ref_head)
    );

    always_comb begin
        op_valid  = (state == SQ_ISSUE);
        op_kind   = cur.op;
        op_wdata  = lfsr_q;
        put_now   = op_valid && (cur.op == OP_PUT);
        take_rsp  = (state == SQ_WAIT) && rsp_valid;
        ref_pop   = take_rsp && (cur.rd == RD_POP);
        want_data = (cur.rd != RD_NONE);
        mismatch  = (rsp_state != cur.exp_st)
                 || (rsp_rdata_valid != want_data)
                 || (want_data && (rsp_rdata != ref_head));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SQ_START;
            step        <= '0;
            tmo         <= '0;
            fail_q      <= 1'b0;
            fail_step_q <= '0;
            done_q      <= 1'b0;
        end else begin
            case (state)
                SQ_START: state <= SQ_ISSUE;
                SQ_ISSUE: begin
                    state <= SQ_WAIT;
                    tmo   <= '0;
                end
                SQ_WAIT: begin
                    if (rsp_valid) begin
                        if (mismatch && !fail_q) begin
                            fail_q      <= 1'b1;
                            fail_step_q <= step;
                        end
                        if (last) begin
                            state  <= SQ_DONE;
                            done_q <= 1'b1;
                        end else begin
                            step  <= step + STEP_W'(1);
                            state <= SQ_ISSUE;
                        end
                    end else if (tmo == TMO_W'(TIMEOUT - 1)) begin
                        state  <= SQ_DONE;
                        done_q <= 1'b1;
                        if (!fail_q) begin
                            fail_q      <= 1'b1;
                            fail_step_q <= step;
                        end
                    end else begin
                        tmo <= tmo + TMO_W'(1);
                    end
                end
                default: state <= SQ_DONE;
            endcase
        end
    end

    assign done      = done_q;
    assign fail      = fail_q;
    assign pass      = done_q && !fail_q;
    assign fail_step = fail_step_q;

    // R2: a request lasts exactly one cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> !op_valid);

    // R2: no new request while the previous one is unanswered
    a_r2_wait_for_rsp: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_WAIT && !rsp_valid) |=> !op_valid);

    // R9: the first failure and its step index are frozen
    a_r9_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        fail |=> fail && $stable(fail_step));

    // R11: done persists and silences the request port
    a_r11_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done && !op_valid);

    // R10: the wait counter never passes the configured limit
    a_r10_wait_bounded: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_WAIT) |-> tmo < TMO_W'(TIMEOUT));
endmodule

// File: tb/fts_put_cover_seq_tb.sv
module fts_put_cover_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 5;
    localparam int TMO        = 12;
    localparam int NST        = 2 * DEPTH + 7;
    localparam int SW         = $clog2(NST);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          op_valid;
    logic [1:0]    op_kind;
    logic [15:0]   op_wdata;
    logic          rsp_valid = 1'b0;
    logic [2:0]    rsp_state = '0;
    logic          rsp_rdata_valid = 1'b0;
    logic [15:0]   rsp_rdata = '0;
    logic          done;
    logic          pass;
    logic          fail;
    logic [SW-1:0] fail_step;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fts_put_cover_seq #(.DEPTH(DEPTH), .TIMEOUT(TMO), .SEED(16'hACE1)) u_dut (
        .clk             (clk),
        .rst             (rst),
        .op_valid        (op_valid),
        .op_kind         (op_kind),
        .op_wdata        (op_wdata),
        .rsp_valid       (rsp_valid),
        .rsp_state       (rsp_state),
        .rsp_rdata_valid (rsp_rdata_valid),
        .rsp_rdata       (rsp_rdata),
        .done            (done),
        .pass            (pass),
        .fail            (fail),
        .fail_step       (fail_step)
    );

    int checks   = 0;
    int failures = 0;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected operation code per step, taken from R4..R7
    function automatic int exp_kind(int s);
        if (s <= DEPTH)         return 0;
        if (s <= 2 * DEPTH + 2) return 1;
        if (s == 2 * DEPTH + 4) return 2;
        if (s == 2 * DEPTH + 6) return 1;
        return 0;
    endfunction

    function automatic string step_req(int s);
        if (s <= DEPTH)         return "R4";
        if (s <= 2 * DEPTH + 1) return "R5";
        if (s <= 2 * DEPTH + 3) return "R6";
        return "R7";
    endfunction

    function automatic int lfsr_step(int v);
        int fb;
        fb = ((v >> 15) ^ (v >> 13) ^ (v >> 12) ^ (v >> 10)) & 1;
        return ((v << 1) | fb) & 16'hFFFF;
    endfunction

    // Behavioural queue with blocking requests
    int q[$];
    int pend;        // 0 none, 1 put, 2 get, 3 peek
    int pend_data;
    int nstep;
    int cd;
    bit busy;
    int rsp_for;
    bit exp_done;
    int exp_lfsr;
    int fa_step, fa_kind, fb_step, fb_kind;   // kinds: 1 data, 2 state, 3 silent, 4 spurious data
    bit track_done;

    function automatic int qstate();
        if (q.size() == 0)     return 0;
        if (q.size() == DEPTH) return 2;
        return 1;
    endfunction

    task automatic apply_fault(int kind);
        case (kind)
            1: rsp_rdata = rsp_rdata ^ 16'h0001;
            2: rsp_state = rsp_state ^ 3'd1;
            4: rsp_rdata_valid = ~rsp_rdata_valid;
            default: ;
        endcase
    endtask

    int r_st, r_dv, r_dat;

    always @(negedge clk) begin
        if (rst) begin
            q.delete();
            pend = 0; nstep = 0; cd = -1; busy = 0; exp_done = 0;
            exp_lfsr = 16'hACE1;
            rsp_valid = 0; rsp_rdata_valid = 0;
        end else begin
            if (rsp_valid) begin
                if (rsp_for == NST - 1) exp_done = 1;
                rsp_valid = 0;
                busy = 0;
            end
            if (track_done) chk("R11", "done each cycle", done, exp_done);
            if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    rsp_valid = 1;
                    rsp_state = 3'(r_st);
                    rsp_rdata_valid = r_dv[0];
                    rsp_rdata = 16'(r_dat);
                    if (rsp_for == fa_step) apply_fault(fa_kind);
                    if (rsp_for == fb_step) apply_fault(fb_kind);
                    cd = -1;
                end
            end
            if (op_valid) begin
                chk("R2", "request while busy", int'(busy), 0);
                chk(step_req(nstep), $sformatf("op code step %0d", nstep), op_kind, exp_kind(nstep));
                r_dv = 0; r_dat = 0;
                if (op_kind == 2'd0) begin
                    chk("R3", $sformatf("put word step %0d", nstep), op_wdata, exp_lfsr);
                    exp_lfsr = lfsr_step(exp_lfsr);
                    if (pend == 2) begin
                        r_st = 0; r_dv = 1; r_dat = op_wdata; pend = 0;
                    end else if (pend == 3) begin
                        q.push_back(op_wdata); r_st = qstate(); r_dv = 1; r_dat = op_wdata; pend = 0;
                    end else if (q.size() == DEPTH) begin
                        pend = 1; pend_data = op_wdata; r_st = 3;
                    end else begin
                        q.push_back(op_wdata); r_st = qstate();
                    end
                end else if (op_kind == 2'd1) begin
                    if (q.size() == 0) begin
                        pend = 2; r_st = 4;
                    end else begin
                        r_dat = q.pop_front(); r_dv = 1;
                        if (pend == 1) begin q.push_back(pend_data); pend = 0; end
                        r_st = qstate();
                    end
                end else begin
                    if (q.size() == 0) begin
                        pend = 3; r_st = 5;
                    end else begin
                        r_dat = q[0]; r_dv = 1; r_st = qstate();
                    end
                end
                busy = 1;
                rsp_for = nstep;
                cd = ((nstep == fa_step && fa_kind == 3) || (nstep == fb_step && fb_kind == 3))
                     ? -1 : 1 + (nstep % 3);
                nstep++;
            end
        end
    end

    task automatic run_case(string req, int sa, int ka, int sb, int kb,
                            bit exp_fail, int exp_step, int exp_ops);
        fa_step = sa; fa_kind = ka; fb_step = sb; fb_kind = kb;
        track_done = (ka != 3) && (kb != 3);
        @(negedge clk); #1 rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "op_valid in reset", op_valid, 0);
        chk("R1", "done in reset", done, 0);
        chk("R1", "fail in reset", fail, 0);
        chk("R1", "pass in reset", pass, 0);
        #1 rst = 1'b0;
        begin
            int n = 0;
            while (!done && n < 2000) begin @(negedge clk); n++; end
            if (!done) begin
                checks++; failures++;
                $display("FAIL %s run watchdog actual=0 expected=1", req);
            end
        end
        repeat (4) @(negedge clk);
        #1;
        chk("R11", "done at end", done, 1);
        chk(req, "fail verdict", fail, int'(exp_fail));
        chk("R11", "pass verdict", pass, int'(!exp_fail));
        if (exp_fail) chk("R9", "first failing step", fail_step, exp_step);
        chk(exp_fail && (ka == 3) ? "R10" : "R11", "requests issued", nstep, exp_ops);
    endtask

    initial begin
        fa_step = -1; fa_kind = 0; fb_step = -1; fb_kind = 0; track_done = 0;
        // clean queue: whole sequence passes (R4 R5 R6 R7 R11)
        run_case("R11", -1, 0, -1, 0, 1'b0, 0, NST);
        // wrong word returned when the blocked put is released (R5, R8)
        run_case("R5", DEPTH + 1, 1, -1, 0, 1'b1, DEPTH + 1, NST);
        // overfilling put not reported as blocked (R4)
        run_case("R4", DEPTH, 2, -1, 0, 1'b1, DEPTH, NST);
        // released get returns a bad word, then a later bad state: first one kept (R6, R9)
        run_case("R6", 2 * DEPTH + 3, 1, 2 * DEPTH + 4, 2, 1'b1, 2 * DEPTH + 3, NST);
        // put releasing the blocked peek reports the wrong state (R7)
        run_case("R7", 2 * DEPTH + 5, 2, -1, 0, 1'b1, 2 * DEPTH + 5, NST);
        // blocked get wrongly returns a data word (R8)
        run_case("R8", 2 * DEPTH + 2, 4, -1, 0, 1'b1, 2 * DEPTH + 2, NST);
        // queue never answers the very first put (R10)
        run_case("R10", 0, 3, -1, 0, 1'b1, 0, 1);
        // queue stalls mid-drain (R10)
        run_case("R10", DEPTH + 3, 3, -1, 0, 1'b1, DEPTH + 3, DEPTH + 4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; failures++;
        $display("FAIL watchdog global actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule